// File: doc/BRIEF.md
# Fetch Next-PC Predictor with Slow-Direction Override

This block produces the fetch address for every cycle. A direct-mapped next-line table, indexed by the current fetch PC, does two jobs. It acts as a target cache, holding the taken-target and a hit/miss result. It also acts as a bimodal direction predictor, using a 2-bit counter per entry. Together these give a one-cycle guess for the following fetch address. When the table hits and the counter leans taken, the stored target is fetched next. Otherwise fetch continues at PC+4, and only one branch per fetch block is ever predicted.

Two correction paths can override the guess. A slower, more accurate direction predictor reports its decision for the previous fetch one cycle late. When it disagrees with the fast guess, the instruction fetched under that guess is squashed and fetch restarts at the corrected address. Decode can also redirect fetch to a computed taken target when the guess missed or had the wrong target. Branch resolution trains the table through an update port.

Top module: `fetch_npc_unit`

## Requirements
- R1: While reset is held and directly after it, `fetch_pc` equals the `RESET_VEC` parameter (default 0x0000_1000), and every table entry is invalid, so `pred_hit` is 0.
- R2: When there is no redirect, no override, and no taken prediction (a table miss, or a counter value of 0 or 1), the next `fetch_pc` is the current one plus 4.
- R3: When the table hits (valid entry and tag PC[15:8] matches at index PC[7:2]) and the counter is 2 or 3, `pred_taken` is 1. The next `fetch_pc` is the stored target, with no flush.
- R4: A resolved taken update that misses the table allocates the entry. It sets valid, stores the tag and target, and sets the counter to 2 (weakly taken).
- R5: A resolved update that hits the table moves the counter up for taken and down for not-taken. The counter saturates at 3 and at 0, and its upper bit is the predicted direction.
- R6: A resolved taken update that hits but carries a different target rewrites the stored target.
- R7: An entry whose index matches but whose tag differs counts as a miss, and gives a sequential next PC.
- R8: A decode redirect asserts `flush` in its cycle, and the next `fetch_pc` is `dec_tgt`.
- R9: A slow-predictor result (`ovr_vld`) applies to the previous cycle's fetch. When its direction differs from the fast guess made then, `flush` is asserted, and the next `fetch_pc` is `ovr_tgt` (taken) or the previous PC plus 4 (not-taken). A result that agrees has no effect.
- R10: A decode redirect takes priority over a slow-predictor override in the same cycle.
- R11: A slow-predictor result is ignored in the first cycle after reset or after any redirect, because the fetch it refers to was never issued or was squashed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | output | 32 | Address fetched this cycle |
| pred_hit | output | 1 | Next-line table hit for `fetch_pc` |
| pred_taken | output | 1 | Fast guess: hit and counter leans taken |
| flush | output | 1 | Instruction fetched this cycle is squashed |
| upd_vld | input | 1 | Branch resolution update strobe |
| upd_pc | input | 32 | Address of the resolved branch's fetch line |
| upd_taken | input | 1 | Resolved direction |
| upd_tgt | input | 32 | Resolved taken target |
| dec_redir | input | 1 | Decode redirect request |
| dec_tgt | input | 32 | Redirect address computed at decode |
| ovr_vld | input | 1 | Slow direction result valid (for previous fetch) |
| ovr_taken | input | 1 | Slow direction result |
| ovr_tgt | input | 32 | Taken target accompanying the slow result |

## Verification
The table is trained with counter sequences that cross the taken/not-taken threshold in both directions and press against both saturation limits. This separates a counter that wraps from one that saturates, and shows whether the prediction comes from the counter's upper bit. An aliasing address with the same index and another tag shows whether the tag compare really takes part in a hit. The target is then retrained to show whether it is rewritten or kept. Slow-predictor results are applied in disagreeing, agreeing, redirect-coinciding and just-after-redirect cycles. These tell a correct override apart from one that ignores agreement, loses the priority to decode, or acts on a squashed fetch.

// File: rtl/fnp_pkg.sv
package fnp_pkg;
  localparam int XLEN = 32;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_TAKEN = 2'd2;

  function automatic logic [XLEN-1:0] pc_plus4(input logic [XLEN-1:0] pc);
    return pc + 32'd4;
  endfunction

  // saturating 2-bit step toward the resolved direction
  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    if (taken) return (c == 2'd3) ? c : c + 2'd1;
    else       return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  function automatic logic ctr_dir(input ctr_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/fnp_line_table.sv
module fnp_line_table
  import fnp_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int TAG_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] lk_pc,
  output logic            lk_hit,
  output logic            lk_dir,
  output logic [XLEN-1:0] lk_tgt,
  input  logic            up_vld,
  input  logic [XLEN-1:0] up_pc,
  input  logic            up_taken,
  input  logic [XLEN-1:0] up_tgt
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int IDX_LO = 2;
  localparam int TAG_LO = IDX_LO + IDX_W;

  logic             valid_q [DEPTH];
  ctr_t             ctr_q   [DEPTH];
  logic [TAG_W-1:0] tag_q   [DEPTH];
  logic [XLEN-1:0]  tgt_q   [DEPTH];

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic             up_hit, up_alloc, up_train;

  assign lk_idx = lk_pc[TAG_LO-1:IDX_LO];
  assign lk_tag = lk_pc[TAG_LO+TAG_W-1:TAG_LO];
  assign up_idx = up_pc[TAG_LO-1:IDX_LO];
  assign up_tag = up_pc[TAG_LO+TAG_W-1:TAG_LO];

  assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_dir = ctr_dir(ctr_q[lk_idx]);
  assign lk_tgt = tgt_q[lk_idx];

  // named update events
  assign up_hit   = valid_q[up_idx] && (tag_q[up_idx] == up_tag);
  assign up_alloc = up_vld && up_taken && (!up_hit || (tgt_q[up_idx] != up_tgt));
  assign up_train = up_vld && up_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        valid_q[i] <= 1'b0;
        ctr_q[i]   <= '0;
      end
    end else if (up_alloc) begin
      valid_q[up_idx] <= 1'b1;
      ctr_q[up_idx]   <= up_hit ? ctr_step(ctr_q[up_idx], 1'b1) : CTR_WEAK_TAKEN;
    end else if (up_train) begin
      ctr_q[up_idx] <= ctr_step(ctr_q[up_idx], up_taken);
    end
  end

  always_ff @(posedge clk) begin
    if (up_alloc) begin
      tag_q[up_idx] <= up_tag;
      tgt_q[up_idx] <= up_tgt;
    end
  end

  p_alloc_r4: assert property (@(posedge clk) disable iff (rst)
    (up_vld && up_taken && !up_hit) |=>
      (valid_q[$past(up_idx)] && ctr_q[$past(up_idx)] == CTR_WEAK_TAKEN))
    else $error("p_alloc_r4");

  p_sat_hi_r5: assert property (@(posedge clk) disable iff (rst)
    (up_train && up_taken && ctr_q[up_idx] == 2'd3) |=> (ctr_q[$past(up_idx)] == 2'd3))
    else $error("p_sat_hi_r5");

  p_sat_lo_r5: assert property (@(posedge clk) disable iff (rst)
    (up_train && !up_taken && ctr_q[up_idx] == 2'd0) |=> (ctr_q[$past(up_idx)] == 2'd0))
    else $error("p_sat_lo_r5");

  p_retarget_r6: assert property (@(posedge clk) disable iff (rst)
    (up_vld && up_taken && up_hit && tgt_q[up_idx] != up_tgt) |=>
      (tgt_q[$past(up_idx)] == $past(up_tgt)))
    else $error("p_retarget_r6");
endmodule

// File: rtl/fnp_pc_select.sv
module fnp_pc_select
  import fnp_pkg::*;
(
  input  logic [XLEN-1:0] cur_pc,
  input  logic            dec_redir,
  input  logic [XLEN-1:0] dec_tgt,
  input  logic            ovr_fire,
  input  logic [XLEN-1:0] ovr_pc,
  input  logic            fast_taken,
  input  logic [XLEN-1:0] fast_tgt,
  output logic [XLEN-1:0] nxt_pc
);
  // priority: decode, slow override, fast guess, sequential
  always_comb begin
    if (dec_redir)       nxt_pc = dec_tgt;
    else if (ovr_fire)   nxt_pc = ovr_pc;
    else if (fast_taken) nxt_pc = fast_tgt;
    else                 nxt_pc = pc_plus4(cur_pc);
  end
endmodule

// File: rtl/fetch_npc_unit.sv
module fetch_npc_unit
  import fnp_pkg::*;
#(
  parameter logic [31:0] RESET_VEC = 32'h0000_1000,
  parameter int          IDX_W     = 6,
  parameter int          TAG_W     = 8
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] fetch_pc,
  output logic        pred_hit,
  output logic        pred_taken,
  output logic        flush,
  input  logic        upd_vld,
  input  logic [31:0] upd_pc,
  input  logic        upd_taken,
  input  logic [31:0] upd_tgt,
  input  logic        dec_redir,
  input  logic [31:0] dec_tgt,
  input  logic        ovr_vld,
  input  logic        ovr_taken,
  input  logic [31:0] ovr_tgt
);
  logic [XLEN-1:0] pc_q, nxt_pc, fast_tgt, ovr_pc, prev_pc_q;
  logic            lk_hit, lk_dir, fast_taken;
  logic            prev_vld_q, prev_taken_q, ovr_fire, redirect;

  fnp_line_table #(.IDX_W(IDX_W), .TAG_W(TAG_W)) tbl_i (
    .clk(clk), .rst(rst),
    .lk_pc(pc_q), .lk_hit(lk_hit), .lk_dir(lk_dir), .lk_tgt(fast_tgt),
    .up_vld(upd_vld), .up_pc(upd_pc), .up_taken(upd_taken), .up_tgt(upd_tgt)
  );

  assign fast_taken = lk_hit && lk_dir;

  // slow result refers to the fetch of the previous cycle
  assign ovr_fire = ovr_vld && prev_vld_q && (ovr_taken != prev_taken_q);
  assign ovr_pc   = ovr_taken ? ovr_tgt : pc_plus4(prev_pc_q);
  assign redirect = dec_redir || ovr_fire;

  fnp_pc_select sel_i (
    .cur_pc(pc_q), .dec_redir(dec_redir), .dec_tgt(dec_tgt),
    .ovr_fire(ovr_fire), .ovr_pc(ovr_pc),
    .fast_taken(fast_taken), .fast_tgt(fast_tgt), .nxt_pc(nxt_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q         <= RESET_VEC;
      prev_vld_q   <= 1'b0;
      prev_taken_q <= 1'b0;
      prev_pc_q    <= RESET_VEC;
    end else begin
      pc_q         <= nxt_pc;
      prev_vld_q   <= !redirect;
      prev_taken_q <= fast_taken;
      prev_pc_q    <= pc_q;
    end
  end

  assign fetch_pc   = pc_q;
  assign pred_hit   = lk_hit;
  assign pred_taken = fast_taken;
  assign flush      = redirect;

  p_seq_r2: assert property (@(posedge clk) disable iff (rst)
    (!dec_redir && !ovr_fire && !fast_taken) |=> (fetch_pc == $past(fetch_pc) + 32'd4))
    else $error("p_seq_r2");

  p_fast_r3: assert property (@(posedge clk) disable iff (rst)
    (!dec_redir && !ovr_fire && fast_taken) |=> (fetch_pc == $past(fast_tgt)))
    else $error("p_fast_r3");

  p_dec_r8: assert property (@(posedge clk) disable iff (rst)
    dec_redir |=> (fetch_pc == $past(dec_tgt)))
    else $error("p_dec_r8");

  p_ovr_r9: assert property (@(posedge clk) disable iff (rst)
    (ovr_fire && !dec_redir) |=> (fetch_pc == $past(ovr_pc)))
    else $error("p_ovr_r9");

  p_stale_r11: assert property (@(posedge clk) disable iff (rst)
    (!prev_vld_q && !dec_redir) |-> !flush)
    else $error("p_stale_r11");
endmodule

// File: tb/fetch_npc_unit_tb_top.sv
module fetch_npc_unit_tb_top;
  localparam logic [31:0] RVEC = 32'h0000_1000;
  localparam logic [31:0] PA   = 32'h0000_2010;
  localparam logic [31:0] PB   = 32'h0000_2110; // same index as PA, other tag

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] fetch_pc;
  logic pred_hit, pred_taken, flush;
  logic upd_vld = 0, upd_taken = 0, dec_redir = 0, ovr_vld = 0, ovr_taken = 0;
  logic [31:0] upd_pc = 0, upd_tgt = 0, dec_tgt = 0, ovr_tgt = 0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  fetch_npc_unit #(.RESET_VEC(RVEC)) dut_i (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_hit(pred_hit),
    .pred_taken(pred_taken), .flush(flush),
    .upd_vld(upd_vld), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_tgt(upd_tgt),
    .dec_redir(dec_redir), .dec_tgt(dec_tgt),
    .ovr_vld(ovr_vld), .ovr_taken(ovr_taken), .ovr_tgt(ovr_tgt)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic train(input logic [31:0] pc, input logic tk, input logic [31:0] tg);
    upd_vld = 1; upd_pc = pc; upd_taken = tk; upd_tgt = tg;
    tick();
    upd_vld = 0;
  endtask

  // redirect to pc; after return fetch_pc == pc
  task automatic go_to(input logic [31:0] pc);
    dec_redir = 1; dec_tgt = pc;
    tick();
    dec_redir = 0;
  endtask

  task automatic t_reset();
    chk(fetch_pc == RVEC, "R1 pc in reset", fetch_pc, RVEC);
    rst = 0;
    #1;
    chk(pred_hit == 0, "R1 table empty", pred_hit, 0);
    tick();
    chk(fetch_pc == RVEC + 4, "R2 sequential after reset", fetch_pc, RVEC + 4);
  endtask

  task automatic t_alloc();
    train(PA, 1, 32'h3000);
    dec_redir = 1; dec_tgt = PA;
    #1;
    chk(flush == 1, "R8 flush on decode redirect", flush, 1);
    tick();
    dec_redir = 0;
    chk(fetch_pc == PA, "R8 pc from decode", fetch_pc, PA);
    chk(pred_taken == 1, "R4 allocated weakly taken", pred_taken, 1);
    #1;
    chk(flush == 0, "R3 no flush on fast guess", flush, 0);
    tick();
    chk(fetch_pc == 32'h3000, "R3 fetch stored target", fetch_pc, 32'h3000);
  endtask

  task automatic probe(input logic exp_t, input string req);
    go_to(PA);
    chk(pred_taken == exp_t, req, pred_taken, exp_t);
  endtask

  task automatic t_counter();
    train(PA, 1, 32'h3000); train(PA, 1, 32'h3000); // 3, saturated
    train(PA, 0, 0);                                // 2
    probe(1, "R5 top saturation keeps taken");
    train(PA, 0, 0);                                // 1
    probe(0, "R5 counter 1 predicts not-taken");
    tick();
    chk(fetch_pc == PA + 4, "R2 hit but not-taken is sequential", fetch_pc, PA + 4);
    train(PA, 0, 0); train(PA, 0, 0); train(PA, 0, 0); // 0 saturated
    train(PA, 1, 32'h3000);                         // 1
    probe(0, "R5 bottom saturation");
    train(PA, 1, 32'h3000);                         // 2
    probe(1, "R5 counter 2 predicts taken");
  endtask

  task automatic t_retarget();
    train(PA, 1, 32'h4000);                         // ctr 3, new target
    go_to(PA);
    tick();
    chk(fetch_pc == 32'h4000, "R6 target rewritten", fetch_pc, 32'h4000);
  endtask

  task automatic t_alias();
    go_to(PB);
    chk(pred_hit == 0, "R7 tag mismatch misses", pred_hit, 0);
    tick();
    chk(fetch_pc == PB + 4, "R7 alias sequential", fetch_pc, PB + 4);
  endtask

  task automatic t_override();
    go_to(PA); tick();                     // pc=4000, prev=PA taken
    ovr_vld = 1; ovr_taken = 0;
    #1;
    chk(flush == 1, "R9 disagree flushes", flush, 1);
    tick();
    ovr_vld = 0;
    chk(fetch_pc == PA + 4, "R9 not-taken override", fetch_pc, PA + 4);
    go_to(PB); tick();                     // pc=PB+4, prev=PB not-taken
    ovr_vld = 1; ovr_taken = 1; ovr_tgt = 32'h5000;
    tick();
    ovr_vld = 0;
    chk(fetch_pc == 32'h5000, "R9 taken override", fetch_pc, 32'h5000);
    tick();                                // pc=5004, prev=5000 not-taken
    ovr_vld = 1; ovr_taken = 0;
    #1;
    chk(flush == 0, "R9 agreement no flush", flush, 0);
    tick();
    ovr_vld = 0;
    chk(fetch_pc == 32'h5008, "R9 agreement no effect", fetch_pc, 32'h5008);
  endtask

  task automatic t_priority();
    tick();                                // pc=500C, prev valid not-taken
    ovr_vld = 1; ovr_taken = 1; ovr_tgt = 32'h6000;
    dec_redir = 1; dec_tgt = 32'h7000;
    tick();
    chk(fetch_pc == 32'h7000, "R10 decode beats override", fetch_pc, 32'h7000);
    dec_redir = 0;                         // prev invalid now
    #1;
    chk(flush == 0, "R11 stale override ignored", flush, 0);
    tick();
    ovr_vld = 0;
    chk(fetch_pc == 32'h7004, "R11 sequential after stale", fetch_pc, 32'h7004);
  endtask

  initial begin
    tick(); tick(); tick();
    t_reset();
    t_alloc();
    t_counter();
    t_retarget();
    t_alias();
    t_override();
    t_priority();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule